// File: doc/BRIEF.md
# Static RAM Bridge with Address and Data Registers

This block joins the datapath of a small processor to an asynchronous 32K x 8 static RAM. On the processor side there is an 8-bit shared data bus and a set of one-cycle strobes. Two strobes load the address register, one byte at a time. Four strobes move the data register: bus into register, register onto bus, register into memory and memory into register. On the memory side the block drives a 15-bit address, a split 8-bit data port with an output-enable, and the active-low select, write-enable and output-enable lines. Chip select is held active at all times. Reads are gated only by the output-enable line and writes only by the write-enable line.

The processor orders its own steps. A memory read is "load address, then strobe memory-to-register". A memory write is "load address, load the register from the bus, then strobe register-to-memory". The write and read strobes each start a short timed operation. Busy is high for the whole of that operation, and all strobes are ignored while it lasts.

The controller has five states. `IDLE` accepts strobes. `WR_SETUP` lasts one cycle: address and data are presented and write-enable is still high. `WR_PULSE` holds write-enable low for `WE_CYC` cycles. `WR_HOLD` lasts one cycle: write-enable is high again and the data is still driven. `RD_WAIT` holds output-enable low for `RD_CYC` cycles. The transitions are as follows. IDLE→WR_SETUP happens on a lone write strobe. IDLE→RD_WAIT happens on a lone read strobe. WR_SETUP→WR_PULSE is always taken. WR_PULSE→WR_HOLD is taken when the pulse count is done. WR_HOLD→IDLE is always taken. RD_WAIT→IDLE is taken when the access count is done, and the data register captures the RAM data on that cycle.

Top module: `sram_bridge`

## Requirements
- R1: After reset the address and data registers are 0, `mem_we_n`, `mem_oe_n` are 1, `mem_dq_oe`, `busy`, `strobe_err`, `bus_oe` are 0, and `mem_cs_n` is 0.
- R2: While idle, `ld_addr_lo` loads `bus_in[7:0]` into `mem_addr[7:0]`, and `ld_addr_hi` loads `bus_in[6:0]` into `mem_addr[14:8]` (`bus_in[7]` is ignored) at the clock edge.
- R3: A lone `st_bus2mdr` while idle copies `bus_in` into the data register at the clock edge.
- R4: A lone `st_mdr2bus` while idle raises `bus_oe` in that same cycle, with `bus_out` equal to the data register. Otherwise `bus_oe` is 0.
- R5: A lone `st_mdr2mem` starts a write. First comes one cycle with `mem_dq_oe`=1 and `mem_we_n`=1. Then `mem_we_n`=0 for `WE_CYC` cycles (default 2). Then one guard cycle with `mem_dq_oe`=1 and `mem_we_n`=1. Throughout, `mem_dq_out` equals the data register and `mem_addr` equals the address register.
- R6: A lone `st_mem2mdr` starts a read. `mem_oe_n` is 0 for `RD_CYC` cycles (default 2), and the data register takes `mem_dq_in` as sampled at the edge that ends the last of those cycles.
- R7: `mem_oe_n`=0 and `mem_dq_oe`=1 never occur together. `mem_we_n`=0 only while `mem_dq_oe`=1. `mem_cs_n` is always 0.
- R8: `busy` is 1 from the cycle after a memory strobe and lasts exactly the operation: `WE_CYC`+2 cycles for a write, `RD_CYC` cycles for a read.
- R9: While `busy` is 1, all six strobes are ignored. The address and data registers keep their values and `bus_oe` stays 0.
- R10: If more than one of the four data-register strobes is high in a cycle, that cycle has no effect, `bus_oe` stays 0, and `strobe_err` is 1 for the following cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_in | input | 8 | Processor data bus value |
| bus_out | output | 8 | Data register value toward the bus |
| bus_oe | output | 1 | Drive enable for `bus_out` |
| ld_addr_lo | input | 1 | Load low address byte from bus |
| ld_addr_hi | input | 1 | Load high address bits from bus |
| st_bus2mdr | input | 1 | Bus into data register |
| st_mdr2bus | input | 1 | Data register onto bus |
| st_mdr2mem | input | 1 | Data register into RAM |
| st_mem2mdr | input | 1 | RAM into data register |
| mem_addr | output | 15 | RAM address |
| mem_dq_in | input | 8 | RAM data pins, read value |
| mem_dq_out | output | 8 | RAM data pins, write value |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_out` |
| mem_cs_n | output | 1 | RAM select, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| busy | output | 1 | Memory operation in progress |
| strobe_err | output | 1 | Conflicting strobes seen last cycle |

## Verification
The hardest case to reach is a strobe that arrives in the middle of an operation. Such a strobe must change nothing. The bench starts a write and, during its busy window, applies new address bytes, a bus-to-register load and a register-to-bus request. After the write ends, it reads both registers back through the normal paths. Capture timing is also hard to observe, because a capture one cycle late would still look correct if the RAM data stayed valid. The bench's RAM model therefore puts a marker value on `mem_dq_in` whenever output-enable is high.

// File: rtl/sram_bridge_pkg.sv
package sram_bridge_pkg;

    typedef enum logic [2:0] {
        IDLE     = 3'd0,
        WR_SETUP = 3'd1,
        WR_PULSE = 3'd2,
        WR_HOLD  = 3'd3,
        RD_WAIT  = 3'd4
    } xfer_state_e;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_bridge_dec.sv
module sram_bridge_dec (
    input  logic clk,
    input  logic rst_n,
    input  logic idle,
    input  logic st_bus2mdr,
    input  logic st_mdr2bus,
    input  logic st_mdr2mem,
    input  logic st_mem2mdr,
    output logic go_bus2mdr,
    output logic go_mdr2bus,
    output logic go_write,
    output logic go_read,
    output logic strobe_err
);

    localparam int N_STB = 4;

    logic [N_STB-1:0] stb_vec;
    logic             sole;
    logic             clash;
    logic             err_q;

    assign stb_vec = {st_mem2mdr, st_mdr2mem, st_mdr2bus, st_bus2mdr};

    always_comb begin
        sole       = ($countones(stb_vec) == 1);
        clash      = ($countones(stb_vec) > 1);
        go_bus2mdr = idle && sole && st_bus2mdr;
        go_mdr2bus = idle && sole && st_mdr2bus;
        go_write   = idle && sole && st_mdr2mem;
        go_read    = idle && sole && st_mem2mdr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= clash;
    end

    assign strobe_err = err_q;

    // R10: clash is reported on the next cycle, and only then
    assert_clash_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(stb_vec) > 1) |=> strobe_err);
    assert_clash_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(stb_vec) <= 1) |=> !strobe_err);

endmodule

// File: rtl/sram_bridge_fsm.sv
module sram_bridge_fsm
    import sram_bridge_pkg::*;
#(
    parameter int WE_CYC = 2,
    parameter int RD_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go_write,
    input  logic go_read,
    output logic idle,
    output logic busy,
    output logic capture,
    output logic mem_we_n,
    output logic mem_oe_n,
    output logic mem_dq_oe
);

    localparam int MAX_CYC = max2(WE_CYC, RD_CYC);
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] WE_LAST = CNT_W'(WE_CYC - 1);
    localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(RD_CYC - 1);

    xfer_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // next-state and counter
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            IDLE: begin
                cnt_d = '0;
                if (go_write)     state_d = WR_SETUP;
                else if (go_read) state_d = RD_WAIT;
            end
            WR_SETUP: begin
                cnt_d   = '0;
                state_d = WR_PULSE;
            end
            WR_PULSE: begin
                if (cnt_q == WE_LAST) begin
                    cnt_d   = '0;
                    state_d = WR_HOLD;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            WR_HOLD: begin
                state_d = IDLE;
            end
            RD_WAIT: begin
                if (cnt_q == RD_LAST) begin
                    cnt_d   = '0;
                    state_d = IDLE;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                cnt_d   = '0;
                state_d = IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs decoded from state
    always_comb begin
        idle      = 1'b0;
        capture   = 1'b0;
        mem_we_n  = 1'b1;
        mem_oe_n  = 1'b1;
        mem_dq_oe = 1'b0;
        unique case (state_q)
            IDLE:     idle = 1'b1;
            WR_SETUP: mem_dq_oe = 1'b1;
            WR_PULSE: begin
                mem_dq_oe = 1'b1;
                mem_we_n  = 1'b0;
            end
            WR_HOLD:  mem_dq_oe = 1'b1;
            RD_WAIT: begin
                mem_oe_n = 1'b0;
                capture  = (cnt_q == RD_LAST);
            end
            default:  idle = 1'b0;
        endcase
    end

    assign busy = !idle;

    // length of the current write-enable low run, for the pulse-width check
    logic [CNT_W:0] we_run_q;
    always_ff @(posedge clk) begin
        if (!rst_n)        we_run_q <= '0;
        else if (!mem_we_n) we_run_q <= we_run_q + 1'b1;
        else               we_run_q <= '0;
    end

    assert_bus_fight_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && mem_dq_oe));
    assert_we_needs_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_dq_oe);
    assert_data_before_we_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> $past(mem_dq_oe));
    assert_data_after_we_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> mem_dq_oe);
    assert_we_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_run_q == (CNT_W+1)'(WE_CYC)));
    assert_start_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (go_write || go_read) |=> busy);

endmodule

// File: rtl/sram_bridge_regs.sv
module sram_bridge_regs #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idle,
    input  logic              ld_addr_lo,
    input  logic              ld_addr_hi,
    input  logic              go_bus2mdr,
    input  logic              capture,
    input  logic [DATA_W-1:0] bus_in,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [ADDR_W-1:0] mar,
    output logic [DATA_W-1:0] mdr
);

    localparam int HI_W = ADDR_W - DATA_W;

    logic [DATA_W-1:0] mar_lo_q;
    logic [HI_W-1:0]   mar_hi_q;
    logic [DATA_W-1:0] mdr_q;

    // address register, two byte lanes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mar_lo_q <= '0;
            mar_hi_q <= '0;
        end else if (idle) begin
            if (ld_addr_lo) mar_lo_q <= bus_in;
            if (ld_addr_hi) mar_hi_q <= bus_in[HI_W-1:0];
        end
    end

    generate
        if (HI_W < DATA_W) begin : g_spare
            logic hi_spare_unused;
            assign hi_spare_unused = ^bus_in[DATA_W-1:HI_W];
        end
    endgenerate

    // data register: from bus when idle, from memory at read capture
    always_ff @(posedge clk) begin
        if (!rst_n)          mdr_q <= '0;
        else if (capture)    mdr_q <= mem_dq_in;
        else if (go_bus2mdr) mdr_q <= bus_in;
    end

    assign mar = {mar_hi_q, mar_lo_q};
    assign mdr = mdr_q;

    assert_addr_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |=> $stable(mar));
    assert_data_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && !capture) |=> $stable(mdr));
    assert_bus_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        go_bus2mdr |=> (mdr == $past(bus_in)));

endmodule

// File: rtl/sram_bridge.sv
module sram_bridge #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 15,
    parameter int WE_CYC = 2,
    parameter int RD_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    input  logic              ld_addr_lo,
    input  logic              ld_addr_hi,
    input  logic              st_bus2mdr,
    input  logic              st_mdr2bus,
    input  logic              st_mdr2mem,
    input  logic              st_mem2mdr,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic              busy,
    output logic              strobe_err
);

    logic idle, capture;
    logic go_bus2mdr, go_mdr2bus, go_write, go_read;
    logic [DATA_W-1:0] mdr;

    sram_bridge_dec u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .idle       (idle),
        .st_bus2mdr (st_bus2mdr),
        .st_mdr2bus (st_mdr2bus),
        .st_mdr2mem (st_mdr2mem),
        .st_mem2mdr (st_mem2mdr),
        .go_bus2mdr (go_bus2mdr),
        .go_mdr2bus (go_mdr2bus),
        .go_write   (go_write),
        .go_read    (go_read),
        .strobe_err (strobe_err)
    );

    sram_bridge_fsm #(
        .WE_CYC (WE_CYC),
        .RD_CYC (RD_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .go_write  (go_write),
        .go_read   (go_read),
        .idle      (idle),
        .busy      (busy),
        .capture   (capture),
        .mem_we_n  (mem_we_n),
        .mem_oe_n  (mem_oe_n),
        .mem_dq_oe (mem_dq_oe)
    );

    sram_bridge_regs #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .idle       (idle),
        .ld_addr_lo (ld_addr_lo),
        .ld_addr_hi (ld_addr_hi),
        .go_bus2mdr (go_bus2mdr),
        .capture    (capture),
        .bus_in     (bus_in),
        .mem_dq_in  (mem_dq_in),
        .mar        (mem_addr),
        .mdr        (mdr)
    );

    assign bus_out    = mdr;
    assign bus_oe     = go_mdr2bus;
    assign mem_dq_out = mdr;
    assign mem_cs_n   = 1'b0;

    assert_bus_drive_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> !busy);
    assert_write_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (mem_dq_out == bus_out));

endmodule

// File: tb/sram_bridge_tb_top.sv
module sram_bridge_tb_top;

    localparam int WE_CYC = 2;
    localparam int RD_CYC = 2;
    localparam logic [7:0] FLOAT_MARK = 8'hEE;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  bus_in;
    logic [7:0]  bus_out;
    logic        bus_oe;
    logic        ld_addr_lo, ld_addr_hi;
    logic        st_bus2mdr, st_mdr2bus, st_mdr2mem, st_mem2mdr;
    logic [14:0] mem_addr;
    logic [7:0]  mem_dq_in;
    logic [7:0]  mem_dq_out;
    logic        mem_dq_oe, mem_cs_n, mem_we_n, mem_oe_n, busy, strobe_err;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [7:0] ram [int];

    always #10 clk = ~clk;

    sram_bridge dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_in     (bus_in),
        .bus_out    (bus_out),
        .bus_oe     (bus_oe),
        .ld_addr_lo (ld_addr_lo),
        .ld_addr_hi (ld_addr_hi),
        .st_bus2mdr (st_bus2mdr),
        .st_mdr2bus (st_mdr2bus),
        .st_mdr2mem (st_mdr2mem),
        .st_mem2mdr (st_mem2mdr),
        .mem_addr   (mem_addr),
        .mem_dq_in  (mem_dq_in),
        .mem_dq_out (mem_dq_out),
        .mem_dq_oe  (mem_dq_oe),
        .mem_cs_n   (mem_cs_n),
        .mem_we_n   (mem_we_n),
        .mem_oe_n   (mem_oe_n),
        .busy       (busy),
        .strobe_err (strobe_err)
    );

    // RAM model: writes while WE low, read data only while OE low
    always @(negedge clk) begin
        if (mem_we_n === 1'b0 && mem_dq_oe === 1'b1)
            ram[int'(mem_addr)] = mem_dq_out;
        if (mem_oe_n === 1'b0)
            mem_dq_in = ram.exists(int'(mem_addr)) ? ram[int'(mem_addr)] : 8'h00;
        else
            mem_dq_in = FLOAT_MARK;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic clr_strobes();
        ld_addr_lo = 0; ld_addr_hi = 0;
        st_bus2mdr = 0; st_mdr2bus = 0; st_mdr2mem = 0; st_mem2mdr = 0;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic load_addr(input logic [14:0] a);
        bus_in = a[7:0]; ld_addr_lo = 1; tick();
        ld_addr_lo = 0; bus_in = {1'b1, a[14:8]}; ld_addr_hi = 1; tick();
        clr_strobes();
    endtask

    task automatic load_data(input logic [7:0] d);
        bus_in = d; st_bus2mdr = 1; tick();
        clr_strobes();
    endtask

    task automatic see_data(input logic [7:0] exp, input string tag);
        st_mdr2bus = 1; #1;
        chk(bus_oe === 1'b1, {tag, " R4 bus_oe"}, bus_oe, 1);
        chk(bus_out === exp, {tag, " R4 bus_out"}, bus_out, exp);
        tick();
        clr_strobes(); #1;
        chk(bus_oe === 1'b0, {tag, " R4 bus_oe drop"}, bus_oe, 0);
    endtask

    task automatic t_reset();
        rst_n = 0; clr_strobes(); bus_in = 0;
        repeat (3) tick();
        rst_n = 1; tick();
        chk(mem_addr === 15'h0, "R1 addr", mem_addr, 0);
        chk(mem_we_n === 1'b1 && mem_oe_n === 1'b1, "R1 we/oe", {mem_we_n, mem_oe_n}, 3);
        chk(mem_dq_oe === 1'b0 && busy === 1'b0 && strobe_err === 1'b0, "R1 flags",
            {mem_dq_oe, busy, strobe_err}, 0);
        chk(mem_cs_n === 1'b0, "R1 R7 cs", mem_cs_n, 0);
        chk(bus_oe === 1'b0, "R1 bus_oe", bus_oe, 0);
        see_data(8'h00, "R1 data reg");
    endtask

    task automatic t_regs();
        load_addr(15'h5A3C);
        chk(mem_addr === 15'h5A3C, "R2 addr load", mem_addr, 15'h5A3C);
        load_data(8'hC7);
        see_data(8'hC7, "R3 load");
        load_data(8'h01);
        see_data(8'h01, "R3 reload");
    endtask

    task automatic t_write(input logic [14:0] a, input logic [7:0] d);
        load_addr(a);
        load_data(d);
        st_mdr2mem = 1; #1;
        chk(busy === 1'b0, "R8 busy in strobe cycle", busy, 0);
        tick(); clr_strobes();
        chk(busy && mem_we_n && mem_dq_oe, "R5 setup cycle", {busy, mem_we_n, mem_dq_oe}, 7);
        chk(mem_dq_out === d && mem_addr === a, "R5 setup data/addr", mem_dq_out, d);
        for (int i = 0; i < WE_CYC; i++) begin
            tick();
            chk(busy && !mem_we_n && mem_dq_oe && mem_oe_n, "R5 R7 pulse",
                {busy, mem_we_n, mem_dq_oe, mem_oe_n}, 4'b1011);
            chk(mem_dq_out === d && mem_addr === a, "R5 pulse data/addr", mem_dq_out, d);
        end
        tick();
        chk(busy && mem_we_n && mem_dq_oe, "R5 guard cycle", {busy, mem_we_n, mem_dq_oe}, 7);
        tick();
        chk(!busy && !mem_dq_oe, "R8 write end", {busy, mem_dq_oe}, 0);
        chk(ram.exists(int'(a)) && ram[int'(a)] === d, "R5 ram content",
            ram.exists(int'(a)) ? ram[int'(a)] : 'hx, d);
    endtask

    task automatic t_read(input logic [14:0] a, input logic [7:0] exp);
        load_addr(a);
        load_data(8'h33);
        st_mem2mdr = 1; tick(); clr_strobes();
        for (int i = 0; i < RD_CYC; i++) begin
            chk(busy && !mem_oe_n && !mem_dq_oe && mem_we_n, "R6 R7 R8 read window",
                {busy, mem_oe_n, mem_dq_oe, mem_we_n}, 4'b1001);
            tick();
        end
        chk(!busy && mem_oe_n, "R8 read end", {busy, mem_oe_n}, 2'b01);
        see_data(exp, "R6 capture");
    endtask

    task automatic t_busy_ignore();
        load_addr(15'h0123);
        load_data(8'h9D);
        st_mdr2mem = 1; tick(); clr_strobes();
        bus_in = 8'h44; ld_addr_lo = 1; ld_addr_hi = 1; st_bus2mdr = 1; tick();
        clr_strobes(); st_mdr2bus = 1; #1;
        chk(bus_oe === 1'b0, "R9 bus_oe while busy", bus_oe, 0);
        st_mdr2bus = 0; st_mem2mdr = 1; tick(); clr_strobes();
        st_mdr2mem = 1; tick(); clr_strobes();
        while (busy) tick();
        tick();
        chk(!busy && mem_we_n, "R9 no restart", {busy, mem_we_n}, 1);
        chk(mem_addr === 15'h0123, "R9 addr kept", mem_addr, 15'h0123);
        see_data(8'h9D, "R9 data kept");
        chk(ram[int'(15'h0123)] === 8'h9D, "R9 ram", ram[int'(15'h0123)], 8'h9D);
    endtask

    task automatic t_clash();
        load_data(8'h5A);
        bus_in = 8'hFF; st_bus2mdr = 1; st_mem2mdr = 1; tick(); clr_strobes();
        chk(strobe_err === 1'b1, "R10 err raised", strobe_err, 1);
        chk(!busy && mem_oe_n, "R10 no read", {busy, mem_oe_n}, 1);
        tick();
        chk(strobe_err === 1'b0, "R10 err one cycle", strobe_err, 0);
        see_data(8'h5A, "R10 data kept");
        st_mdr2bus = 1; st_mdr2mem = 1; #1;
        chk(bus_oe === 1'b0, "R10 bus_oe blocked", bus_oe, 0);
        tick(); clr_strobes();
        chk(strobe_err && !busy && !mem_dq_oe, "R10 no write", {strobe_err, busy, mem_dq_oe}, 4);
        tick();
    endtask

    initial begin
        mem_dq_in = FLOAT_MARK;
        t_reset();
        t_regs();
        t_write(15'h7FFF, 8'hA5);
        t_write(15'h0000, 8'h3C);
        t_write(15'h2B17, 8'hFF);
        t_read(15'h7FFF, 8'hA5);
        t_read(15'h2B17, 8'hFF);
        t_read(15'h0000, 8'h3C);
        t_read(15'h1111, 8'h00);
        t_busy_ignore();
        t_clash();
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected done");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule